// File: doc/BRIEF.md
# Event Timestamp Capture Latches

This block freezes the current value of a free-running 64-bit time counter when a qualified transmit or receive event pulse arrives, and holds that value until software collects it through a word-wide read port. There is a single transmit latch and a bank of receive latch slots (four by default). A receive pulse comes with a slot index that picks the slot to fill.

Each latch has a valid bit. Once it is set, the latch keeps its first captured time and ignores later events aimed at it. Reading the latch's upper 32-bit word releases and re-arms it. Reading the lower word has no side effect. A receive status word shows every slot's valid bit, so software can flush a stale capture one slot at a time. The transmit latch drives a level interrupt. That interrupt is gated by an enable input.

Top module: `ts_capture_latches`

## Requirements
- R1: After reset every valid bit is clear, `tx_irq` is low, and reads of the general status (address 0) and the receive status (address 1) return 0.
- R2: A `tx_evt` pulse on an idle transmit latch captures `time_now`. In the following cycles bit 0 of the general status (address 0) reads 1, address 2 returns time bits 31:0 and address 3 returns time bits 63:32.
- R3: An `rx_evt` pulse captures `time_now` into the slot named by `rx_slot`. Bit i of the receive status (address 1) is slot i's valid bit, and all upper bits read 0. Slot i's low word is at address 4+2i and its high word at 4+2i+1.
- R4: While a latch's valid bit is set, further events aimed at that latch are ignored, and the first captured time is kept.
- R5: A read of a low-word address returns the captured low half and leaves the valid bits unchanged.
- R6: A read of a high-word address returns the captured high half and clears that latch's valid bit from the next cycle. This re-arms the latch.
- R7: If an event and a high-word read hit the same latch in one cycle, the read returns the old time and the new event is captured, so the valid bit stays set.
- R8: `tx_irq` is high exactly while the transmit valid bit and `irq_en` are both 1. Bit 1 of the general status reflects `tx_irq`.
- R9: A general status read followed by reads of the transmit high word and of every receive high word leaves all valid bits clear.
- R10: `rd_data` is combinational: it shows the addressed word in the same cycle that `rd_en` is high. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 64 | Current time in nanoseconds |
| tx_evt | input | 1 | Qualified transmit event pulse |
| rx_evt | input | 1 | Qualified receive event pulse |
| rx_slot | input | 2 | Receive slot index carried with `rx_evt` |
| irq_en | input | 1 | Transmit interrupt enable |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Word address of the read |
| rd_data | output | 32 | Read data, same cycle as `rd_en` |
| tx_irq | output | 1 | Level transmit-capture interrupt |

## Verification
The assertions assume that reset is asserted before the first useful edge. They also assume that `rd_addr` only matters while `rd_en` is high, and that a latch's captured value is whatever `time_now` held at the capturing edge. The stimulus changes every input only on the falling clock edge, and it samples combinational read data before the next rising edge. The stimulus gives each event a distinct time, so a stale or overwritten capture shows up as a wrong word. It never drives a slot index outside the populated range.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  localparam int TIME_W       = 64;
  localparam int WORD_W       = 32;
  // word address map
  localparam int ADDR_GEN     = 0;
  localparam int ADDR_RXSTAT  = 1;
  localparam int ADDR_TX_LO   = 2;
  localparam int ADDR_TX_HI   = 3;
  localparam int ADDR_RX_BASE = 4;
endpackage

// File: rtl/ts_latch_slot.sv
module ts_latch_slot
  import ts_cap_pkg::*;
#(
  parameter int TW = TIME_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_i,
  input  logic          rel_i,
  input  logic [TW-1:0] time_i,
  output logic          valid_o,
  output logic [TW-1:0] stamp_o
);
  logic          valid_q, valid_d;
  logic [TW-1:0] stamp_q;
  logic          stamp_en;

  always_comb begin
    valid_d  = valid_q;
    stamp_en = 1'b0;
    if (rel_i) valid_d = 1'b0;
    // the release finishes first, so a same-cycle event is accepted
    if (evt_i && (!valid_q || rel_i)) begin
      valid_d  = 1'b1;
      stamp_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stamp_q <= '0;
    else if (stamp_en) stamp_q <= time_i;
  end

  assign valid_o = valid_q;
  assign stamp_o = stamp_q;

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !rel_i) |=> (valid_o && $stable(stamp_o)));

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && (!valid_o || rel_i)) |=> (valid_o && stamp_o == $past(time_i)));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_i && !evt_i) |=> !valid_o);
endmodule

// File: rtl/ts_read_mux.sv
module ts_read_mux
  import ts_cap_pkg::*;
#(
  parameter int NRX = 4,
  parameter int AW  = 4,
  parameter int TW  = TIME_W
) (
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic [TW-1:0]     tx_stamp,
  input  logic [NRX*TW-1:0] rx_stamp,
  input  logic              tx_valid,
  input  logic              tx_irq,
  input  logic [NRX-1:0]    rx_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              tx_rel,
  output logic [NRX-1:0]    rx_rel
);
  localparam int HALF = TW / 2;

  always_comb begin
    rd_data = '0;
    tx_rel  = 1'b0;
    rx_rel  = '0;
    if (rd_en) begin
      if (rd_addr == AW'(ADDR_GEN))
        rd_data = {{(WORD_W-2){1'b0}}, tx_irq, tx_valid};
      if (rd_addr == AW'(ADDR_RXSTAT))
        rd_data = {{(WORD_W-NRX){1'b0}}, rx_valid};
      if (rd_addr == AW'(ADDR_TX_LO))
        rd_data = tx_stamp[HALF-1:0];
      if (rd_addr == AW'(ADDR_TX_HI)) begin
        rd_data = tx_stamp[TW-1:HALF];
        tx_rel  = 1'b1;
      end
      for (int i = 0; i < NRX; i++) begin
        if (rd_addr == AW'(ADDR_RX_BASE + 2*i))
          rd_data = rx_stamp[i*TW +: HALF];
        if (rd_addr == AW'(ADDR_RX_BASE + 2*i + 1)) begin
          rd_data   = rx_stamp[i*TW+HALF +: HALF];
          rx_rel[i] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ts_capture_latches.sv
module ts_capture_latches
  import ts_cap_pkg::*;
#(
  parameter int NRX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       time_now,
  input  logic              tx_evt,
  input  logic              rx_evt,
  input  logic [1:0]        rx_slot,
  input  logic              irq_en,
  input  logic              rd_en,
  input  logic [3:0]        rd_addr,
  output logic [31:0]       rd_data,
  output logic              tx_irq
);
  localparam int AW = $clog2(ADDR_RX_BASE + 2*NRX);

  logic                  tx_valid, tx_rel;
  logic [TIME_W-1:0]     tx_stamp;
  logic [NRX-1:0]        rx_valid, rx_rel, rx_hit;
  logic [NRX*TIME_W-1:0] rx_stamp;

  ts_latch_slot #(.TW(TIME_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .evt_i(tx_evt), .rel_i(tx_rel),
    .time_i(time_now), .valid_o(tx_valid), .stamp_o(tx_stamp)
  );

  for (genvar g = 0; g < NRX; g++) begin : g_rx
    assign rx_hit[g] = rx_evt && (rx_slot == 2'(g));
    ts_latch_slot #(.TW(TIME_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .evt_i(rx_hit[g]), .rel_i(rx_rel[g]),
      .time_i(time_now), .valid_o(rx_valid[g]),
      .stamp_o(rx_stamp[g*TIME_W +: TIME_W])
    );
  end

  assign tx_irq = tx_valid && irq_en;

  ts_read_mux #(.NRX(NRX), .AW(AW), .TW(TIME_W)) u_mux (
    .rd_en(rd_en), .rd_addr(rd_addr[AW-1:0]), .tx_stamp(tx_stamp),
    .rx_stamp(rx_stamp), .tx_valid(tx_valid), .tx_irq(tx_irq),
    .rx_valid(rx_valid), .rd_data(rd_data), .tx_rel(tx_rel), .rx_rel(rx_rel)
  );

  p_lowrd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 4'(ADDR_TX_LO) && !tx_evt) |=> (tx_valid == $past(tx_valid)));

  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_irq) |-> irq_en);

  p_rxstat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 4'(ADDR_RXSTAT)) |-> (rd_data[31:NRX] == '0));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));
endmodule

// File: tb/tb_ts_capture_latches.sv
module tb_ts_capture_latches;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] time_now;
  logic        tx_evt, rx_evt, irq_en, rd_en;
  logic [1:0]  rx_slot;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;
  logic        tx_irq;
  int total = 0;
  int bad   = 0;

  ts_capture_latches dut (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .tx_evt(tx_evt),
    .rx_evt(rx_evt), .rx_slot(rx_slot), .irq_en(irq_en), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_irq(tx_irq)
  );

  always #10 clk = ~clk;

  function automatic logic [63:0] mk_time(input logic [31:0] v);
    return {v, v ^ 32'hFFFF_0000};
  endfunction

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic event_op(input bit is_rx, input logic [1:0] slot, input logic [31:0] v);
    time_now = mk_time(v);
    tx_evt = !is_rx; rx_evt = is_rx; rx_slot = slot;
    @(posedge clk); @(negedge clk);
    tx_evt = 1'b0; rx_evt = 1'b0;
  endtask

  task automatic read_op(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  // {req[3:0], op[1:0] (1 tx evt, 2 rx evt, 3 read), idx[3:0], val[31:0], exp[31:0]}
  localparam logic [73:0] VEC [15] = '{
    {4'd2, 2'd1, 4'd0, 32'h11, 32'h0},          // R2 tx capture
    {4'd2, 2'd3, 4'd0, 32'h0,  32'h1},          // R2 tx valid in general status
    {4'd4, 2'd1, 4'd0, 32'h22, 32'h0},          // R4 ignored event
    {4'd5, 2'd3, 4'd2, 32'h0,  32'hFFFF0011},   // R5 low word, first time kept
    {4'd6, 2'd3, 4'd3, 32'h0,  32'h11},         // R6 high word releases
    {4'd6, 2'd3, 4'd0, 32'h0,  32'h0},          // R6 tx valid cleared
    {4'd3, 2'd2, 4'd2, 32'h33, 32'h0},          // R3 slot 2
    {4'd3, 2'd2, 4'd0, 32'h44, 32'h0},          // R3 slot 0
    {4'd3, 2'd3, 4'd1, 32'h0,  32'h5},          // R3 rx status
    {4'd4, 2'd2, 4'd2, 32'h55, 32'h0},          // R4 slot 2 ignores
    {4'd5, 2'd3, 4'd8, 32'h0,  32'hFFFF0033},   // R5 slot 2 low
    {4'd6, 2'd3, 4'd9, 32'h0,  32'h33},         // R6 slot 2 high
    {4'd6, 2'd3, 4'd1, 32'h0,  32'h1},          // R6 only slot 0 left
    {4'd6, 2'd3, 4'd5, 32'h0,  32'h44},         // R6 slot 0 high
    {4'd6, 2'd3, 4'd1, 32'h0,  32'h0}           // R6 all released
  };

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; time_now = '0; tx_evt = 0; rx_evt = 0; rx_slot = 0;
    irq_en = 0; rd_en = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(1, {31'b0, tx_irq}, 32'h0);
    read_op(4'd0, d); check(1, d, 32'h0);
    read_op(4'd1, d); check(1, d, 32'h0);

    for (int i = 0; i < 15; i++) begin
      case (VEC[i][69:68])
        2'd1: event_op(1'b0, 2'd0, VEC[i][63:32]);
        2'd2: event_op(1'b1, VEC[i][65:64], VEC[i][63:32]);
        default: begin
          read_op(VEC[i][67:64], d);
          check(int'(VEC[i][73:70]), d, VEC[i][31:0]);
        end
      endcase
    end

    // R10 unmapped address and idle read data
    read_op(4'd13, d); check(10, d, 32'h0);
    #1 check(10, rd_data, 32'h0);

    // R8 interrupt level and gating
    irq_en = 1'b1;
    event_op(1'b0, 2'd0, 32'h60);
    check(8, {31'b0, tx_irq}, 32'h1);
    read_op(4'd0, d); check(8, d, 32'h3);
    irq_en = 1'b0; #1 check(8, {31'b0, tx_irq}, 32'h0);
    irq_en = 1'b1; #1 check(8, {31'b0, tx_irq}, 32'h1);
    read_op(4'd3, d); check(6, d, 32'h60);
    check(8, {31'b0, tx_irq}, 32'h0);
    irq_en = 1'b0;

    // R7 event and release on the same slot in one cycle
    event_op(1'b1, 2'd1, 32'h66);
    time_now = mk_time(32'h77); rx_evt = 1'b1; rx_slot = 2'd1;
    rd_en = 1'b1; rd_addr = 4'd7;
    #1 d = rd_data;
    @(posedge clk); @(negedge clk);
    rx_evt = 1'b0; rd_en = 1'b0;
    check(7, d, 32'h66);
    read_op(4'd1, d); check(7, d, 32'h2);
    read_op(4'd7, d); check(7, d, 32'h77);

    // R9 fill every latch, then flush with the clearing sequence
    event_op(1'b0, 2'd0, 32'h80);
    for (int s = 0; s < 4; s++) event_op(1'b1, 2'(s), 32'h90 + s);
    read_op(4'd1, d); check(3, d, 32'hF);
    read_op(4'd0, d); check(2, d, 32'h1);
    read_op(4'd3, d); check(9, d, 32'h80);
    for (int s = 0; s < 4; s++) begin
      read_op(4'(5 + 2*s), d); check(9, d, 32'h90 + s);
    end
    read_op(4'd0, d); check(9, d, 32'h0);
    read_op(4'd1, d); check(9, d, 32'h0);

    // R1 reset in the middle clears a held capture
    event_op(1'b1, 2'd3, 32'hA0);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    read_op(4'd1, d); check(1, d, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule